// File: doc/BRIEF.md
# Video Sync Word Normalizer

This block is a single registered stage in a parallel video path. On each rising edge of the parallel clock it takes one 10-bit word. It examines the eight most significant bits for the values that timing-reference words use. If those eight bits are all zeros, the two least significant bits are rewritten to zero. If the eight bits are all ones, the two low bits are rewritten to one. Any other word passes through unchanged.

As a result, an 8-bit source that leaves its two low bits undefined produces the same 10-bit reserved codes as a native 10-bit source. The 10-bit reserved codes are 0x000 to 0x003 and 0x3FC to 0x3FF. Their 8-bit forms are 0x00 and 0xFF.

A disable input turns off the rewrite for streams that do not follow the reserved-code convention. The block presents the normalized word together with a delayed valid flag and a one-cycle flag that marks a detected reserved word.

Top module: `sync_word_normalizer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `out_word` to 0x000 and drives `out_valid` and `out_sync` low after that edge.
- R2: `out_valid` after a clock edge equals `in_valid` sampled at that edge, which is one cycle of latency.
- R3: If `in_valid` is high, `det_off` is low and `in_word[9:2]` is 0x00 at an edge, then after that edge `out_word` is 0x000, whatever `in_word[1:0]` holds.
- R4: If `in_valid` is high, `det_off` is low and `in_word[9:2]` is 0xFF at an edge, then after that edge `out_word` is 0x3FF, whatever `in_word[1:0]` holds.
- R5: If `in_valid` is high and `in_word[9:2]` is neither 0x00 nor 0xFF, then after that edge `out_word` equals `in_word` bit for bit.
- R6: If `in_valid` and `det_off` are both high, then after that edge `out_word` equals `in_word` unmodified and `out_sync` is low, even when the word is a reserved code.
- R7: `out_sync` is high after an edge exactly when that edge captured a word with `in_valid` high, `det_off` low, and `in_word[9:2]` equal to 0x00 or 0xFF. The flag lasts one cycle per such word.
- R8: If `in_valid` is low at an edge, `out_word` keeps its previous value and `out_sync` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 10 | Incoming parallel video word |
| in_valid | input | 1 | Marks `in_word` as carrying data this cycle |
| det_off | input | 1 | High turns off reserved-word detection and rewriting |
| out_word | output | 10 | Normalized word, one cycle after capture |
| out_valid | output | 1 | `in_valid` delayed by one cycle |
| out_sync | output | 1 | One-cycle flag for a detected reserved word |

## Verification
Reserved-word detection can coincide with two qualifiers in the same cycle.

- **Detection disabled.** The bench applies `det_off` in the same cycle as every reserved code, from 0x000 to 0x003 and from 0x3FC to 0x3FF. It then checks that the word comes out untouched and that `out_sync` stays low.
- **Invalid input.** The bench drops `in_valid` while a reserved code sits on `in_word`. It then checks that the previous output word is held and that no sync flag appears.

After the directed cycles, a randomized phase weights reserved codes heavily. During that phase the bench toggles both qualifiers and pulses reset. A behavioural model judges every cycle.

// File: rtl/vsn_pkg.sv
package vsn_pkg;
  typedef enum logic [1:0] {
    RSV_NONE = 2'd0,
    RSV_LOW  = 2'd1,
    RSV_HIGH = 2'd2
  } rsv_kind_e;
endpackage

// File: rtl/vsn_classify.sv
module vsn_classify
  import vsn_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W-1:0] tag,
  output rsv_kind_e        kind
);
  function automatic rsv_kind_e classify(input logic [TAG_W-1:0] t);
    if (t == '0)      return RSV_LOW;
    else if (&t)      return RSV_HIGH;
    else              return RSV_NONE;
  endfunction

  assign kind = classify(tag);
endmodule

// File: rtl/vsn_fix.sv
module vsn_fix
  import vsn_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int FIX_W  = 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  rsv_kind_e         kind,
  input  logic              bypass,
  output logic [WORD_W-1:0] word_o
);
  function automatic logic fix_bit(input logic b, input rsv_kind_e k, input logic off);
    if (off)                return b;
    else if (k == RSV_LOW)  return 1'b0;
    else if (k == RSV_HIGH) return 1'b1;
    else                    return b;
  endfunction

  assign word_o[WORD_W-1:FIX_W] = word_i[WORD_W-1:FIX_W];

  for (genvar i = 0; i < FIX_W; i++) begin : g_low
    assign word_o[i] = fix_bit(word_i[i], kind, bypass);
  end
endmodule

// File: rtl/vsn_stage.sv
module vsn_stage #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] d_word,
  input  logic              d_sync,
  output logic [WORD_W-1:0] q_word,
  output logic              q_valid,
  output logic              q_sync
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_word  <= '0;
      q_valid <= 1'b0;
      q_sync  <= 1'b0;
    end else begin
      q_valid <= load;
      q_sync  <= load & d_sync;
      if (load) q_word <= d_word;
    end
  end
endmodule

// File: rtl/sync_word_normalizer.sv
module sync_word_normalizer
  import vsn_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int FIX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  input  logic              det_off,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  output logic              out_sync
);
  localparam int TAG_W = WORD_W - FIX_W;

  rsv_kind_e         tag_kind;
  logic [WORD_W-1:0] fixed_word;
  logic              rsv_hit;

  vsn_classify #(.TAG_W(TAG_W)) u_cls (
    .tag  (in_word[WORD_W-1:FIX_W]),
    .kind (tag_kind)
  );

  vsn_fix #(.WORD_W(WORD_W), .FIX_W(FIX_W)) u_fix (
    .word_i (in_word),
    .kind   (tag_kind),
    .bypass (det_off),
    .word_o (fixed_word)
  );

  assign rsv_hit = (tag_kind != RSV_NONE) && !det_off;

  vsn_stage #(.WORD_W(WORD_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d_word  (fixed_word),
    .d_sync  (rsv_hit),
    .q_word  (out_word),
    .q_valid (out_valid),
    .q_sync  (out_sync)
  );
endmodule

// File: rtl/vsn_checker.sv
module vsn_checker #(
  parameter int WORD_W = 10,
  parameter int FIX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] in_word,
  input logic              in_valid,
  input logic              det_off,
  input logic [WORD_W-1:0] out_word,
  input logic              out_valid,
  input logic              out_sync,
  input logic              rsv_hit
);
  logic tag_zero, tag_ones;
  assign tag_zero = (in_word[WORD_W-1:FIX_W] == '0);
  assign tag_ones = (&in_word[WORD_W-1:FIX_W]);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_word == '0) && !out_valid && !out_sync);

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  a_r3_zero_fix: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !det_off && tag_zero) |=> (out_word == '0));

  a_r4_ones_fix: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !det_off && tag_ones) |=> (&out_word));

  a_r5_plain_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !tag_zero && !tag_ones) |=> (out_word == $past(in_word)));

  a_r6_off_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && det_off) |=> (out_word == $past(in_word)) && !out_sync);

  a_r7_sync_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_sync == $past(in_valid && rsv_hit));

  a_r7_hit_gated: assert property (@(posedge clk) disable iff (rst)
    det_off |-> !rsv_hit);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word) && !out_sync);
endmodule

bind sync_word_normalizer vsn_checker #(.WORD_W(WORD_W), .FIX_W(FIX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_word  (in_word),
  .in_valid (in_valid),
  .det_off  (det_off),
  .out_word (out_word),
  .out_valid(out_valid),
  .out_sync (out_sync),
  .rsv_hit  (rsv_hit)
);

// File: tb/tb_sync_word_normalizer.sv
`timescale 1ns/1ps
module tb_sync_word_normalizer;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] in_word;
  logic       in_valid;
  logic       det_off;
  logic [9:0] out_word;
  logic       out_valid;
  logic       out_sync;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sync_word_normalizer dut (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .det_off(det_off), .out_word(out_word), .out_valid(out_valid),
    .out_sync(out_sync)
  );

  // Behavioural reference model, updated at each rising edge.
  int    m_word  = 0;
  bit    m_valid = 0;
  bit    m_sync  = 0;
  string m_tag   = "R1";

  always @(posedge clk) begin
    int upper;
    upper = int'(in_word) / 4;
    if (rst) begin
      m_word = 0; m_valid = 0; m_sync = 0; m_tag = "R1";
    end else begin
      m_valid = in_valid;
      if (!in_valid) begin
        m_sync = 0; m_tag = "R8";
      end else if (det_off) begin
        m_word = int'(in_word); m_sync = 0; m_tag = "R6";
      end else if (upper == 0) begin
        m_word = 0; m_sync = 1; m_tag = "R3";
      end else if (upper == 255) begin
        m_word = 1023; m_sync = 1; m_tag = "R4";
      end else begin
        m_word = int'(in_word); m_sync = 0; m_tag = "R5";
      end
    end
  end

  task automatic compare();
    checks++;
    if (int'(out_word) != m_word) begin
      errors++;
      $display("FAIL %s out_word actual=%h expected=%h", m_tag, out_word, m_word[9:0]);
    end
    checks++;
    if (out_valid != m_valid) begin
      errors++;
      $display("FAIL %s R2 out_valid actual=%0b expected=%0b", m_tag, out_valid, m_valid);
    end
    checks++;
    if (out_sync != m_sync) begin
      errors++;
      $display("FAIL %s R7 out_sync actual=%0b expected=%0b", m_tag, out_sync, m_sync);
    end
  endtask

  // Compare the previous edge's result at the falling edge, then drive new inputs.
  task automatic step(input logic r, input logic v, input logic off, input logic [9:0] w);
    @(negedge clk);
    compare();
    rst = r; in_valid = v; det_off = off; in_word = w;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; det_off = 1'b0; in_word = 10'h2A5;
    repeat (3) @(posedge clk);
    // R1: reset state observed
    step(1'b0, 1'b1, 1'b0, 10'h000);
    // R3: low reserved codes collapse to 0x000
    for (int i = 1; i < 4; i++) step(1'b0, 1'b1, 1'b0, 10'(i));
    // R4: high reserved codes collapse to 0x3FF
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 10'(10'h3FC + i));
    // R5: boundary neighbours pass unchanged
    step(1'b0, 1'b1, 1'b0, 10'h004);
    step(1'b0, 1'b1, 1'b0, 10'h3FB);
    step(1'b0, 1'b1, 1'b0, 10'h200);
    step(1'b0, 1'b1, 1'b0, 10'h1FF);
    // R6: detection off in the same cycle as reserved codes
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 10'(i));
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 10'(10'h3FC + i));
    // R8: invalid in the same cycle as reserved codes, word must hold
    step(1'b0, 1'b1, 1'b0, 10'h155);
    step(1'b0, 1'b0, 1'b0, 10'h003);
    step(1'b0, 1'b0, 1'b0, 10'h3FC);
    step(1'b0, 1'b0, 1'b1, 10'h3FE);
    // R7: back-to-back reserved words, then a mid-stream reset (R1)
    step(1'b0, 1'b1, 1'b0, 10'h3FD);
    step(1'b0, 1'b1, 1'b0, 10'h002);
    step(1'b1, 1'b1, 1'b0, 10'h3FF);
    step(1'b0, 1'b1, 1'b0, 10'h0AA);
    // Randomized phase weighted toward reserved codes and qualifiers
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] w;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 3)      w = 10'($urandom_range(0, 3));
      else if (sel < 6) w = 10'($urandom_range(1020, 1023));
      else              w = 10'($urandom_range(0, 1023));
      step(($urandom_range(0, 99) == 0), ($urandom_range(0, 4) != 0),
           ($urandom_range(0, 3) == 0), w);
    end
    step(1'b0, 1'b0, 1'b0, 10'h000);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule